// File: doc/BRIEF.md
# Vector Branch Condition Evaluator

This block decides whether a branch over a vector of condition fields is taken. On a start pulse it captures a vector length, a base field index, a bit selector, a predicate mask and a set of mode bits. It then walks the elements in ascending order, one per clock. For each element it reads one 4-bit condition field through a synchronous read port and folds the element's result into a running AND (all-mode) or OR (any-mode).

The scan stops at the first element that settles the outcome. It can also stop at the first element whose result matches a chosen polarity, and in that case it reports a shortened vector length. Elements whose predicate bit is clear are either skipped or tested against a substitute bit.

On completion the block raises a one-cycle done pulse and presents these results:
- the branch decision;
- a link-register write enable;
- the possibly shortened length;
- the count of predicate-enabled elements that were actually tested, which the surrounding pipeline subtracts from its counter register.

Top module: `vbc_eval`

## Requirements
- R1: Element i reads field address (base_field + i) mod 128, and its test bit is rd_data[bit_sel] (selector value n picks bit n of the field).
- R2: An evaluated element passes when force_pass is 1 or when its test bit equals want_set.
- R3: With all_mode=1 the results are ANDed, starting from 1; the first failing element ends the scan with taken=0.
- R4: With all_mode=0 the results are ORed, starting from 0; the first passing element ends the scan with taken=1.
- R5: Elements are evaluated in ascending order. rd_en is raised only for predicate-enabled elements at or before the exit element, one cycle before the data is used, and never outside a scan.
- R6: An element with predicate bit 0 and sub_en=0 is skipped: it is not read, not counted and has no effect on the decision.
- R7: An element with predicate bit 0 and sub_en=1 uses sub_val as its test bit; it is not read and not counted.
- R8: With trunc_en=1 the scan stops at the first evaluated element i whose result equals trunc_on. vl_out is then i+1 if trunc_incl=1, or i if trunc_incl=0, and vl_trunc=1. Without such a stop, vl_out equals the captured length and vl_trunc=0.
- R9: tested_cnt equals the number of predicate-enabled elements evaluated up to and including the exit element.
- R10: link_we = link_req AND (NOT link_on_taken OR taken).
- R11: A length of 0 completes with done in the cycle right after the start edge, with taken=all_mode, tested_cnt=0 and vl_out=0.
- R12: After reset busy, done, taken, vl_trunc, tested_cnt and rd_en are 0. If a scan with length > 0 exits at element k, done is a single-cycle pulse in the (k+3)-th cycle after the start edge, and the results hold until the next completion.
- R13: A start pulse that arrives while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan (sampled only when idle) |
| vl_in | input | 7 | Vector length, 0..64 |
| base_field | input | 7 | First condition field index |
| bit_sel | input | 2 | Bit of each field to test |
| pred_mask | input | 64 | Per-element predicate, bit i for element i |
| all_mode | input | 1 | 1: AND of results, 0: OR of results |
| force_pass | input | 1 | Every evaluated element passes |
| want_set | input | 1 | Required value of the test bit |
| sub_en | input | 1 | Substitute masked elements instead of skipping |
| sub_val | input | 1 | Substitute test bit for masked elements |
| trunc_en | input | 1 | Enable length truncation |
| trunc_on | input | 1 | Result polarity that triggers truncation |
| trunc_incl | input | 1 | Truncated length includes the stopping element |
| link_req | input | 1 | Instruction asks for a link write |
| link_on_taken | input | 1 | Link write only when taken |
| rd_en | output | 1 | Field read request |
| rd_addr | output | 7 | Field read address |
| rd_data | input | 4 | Field data, valid the cycle after the request edge |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch decision |
| link_we | output | 1 | Link-register write enable |
| vl_out | output | 7 | Resulting vector length |
| vl_trunc | output | 1 | Length was truncated |
| tested_cnt | output | 7 | Predicate-enabled elements tested |

## Verification
A scan of length 0 reports in the first cycle after the start edge. Any other scan spends one priming cycle, then one cycle per element, so results for an exit at element k are due in cycle k+3. The bench captures inputs at the start edge and counts falling edges until done. It compares that count with k+3, computed from its own arithmetic model, and reads all results in the same done cycle. The memory model in the bench counts every read request, so any read past the exit point shows up as a count mismatch.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

   typedef struct packed {
      logic all_mode;
      logic force_pass;
      logic want_set;
      logic sub_en;
      logic sub_val;
      logic trunc_en;
      logic trunc_on;
      logic trunc_incl;
      logic link_req;
      logic link_on_taken;
   } vbc_mode_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PRIME = 2'd1,
      ST_SCAN  = 2'd2
   } vbc_state_t;

endpackage

// File: rtl/vbc_field_addr.sv
module vbc_field_addr #(
   parameter int CRF_COUNT = 128,
   parameter int MAX_VL    = 64,
   localparam int FLD_W    = $clog2(CRF_COUNT),
   localparam int IDX_W    = $clog2(MAX_VL)
) (
   input  logic [FLD_W-1:0] base,
   input  logic [IDX_W-1:0] idx,
   output logic [FLD_W-1:0] addr
);

   localparam bit POW2 = (CRF_COUNT & (CRF_COUNT - 1)) == 0;

   generate
      if (POW2) begin : g_wrap_free
         assign addr = base + FLD_W'(idx);
      end else begin : g_wrap_sub
         logic [FLD_W:0] sum;
         assign sum  = {1'b0, base} + (FLD_W + 1)'(idx);
         assign addr = (sum >= (FLD_W + 1)'(CRF_COUNT))
                       ? FLD_W'(sum - (FLD_W + 1)'(CRF_COUNT))
                       : FLD_W'(sum);
      end
   endgenerate

endmodule

// File: rtl/vbc_elem_test.sv
module vbc_elem_test #(
   parameter int FIELD_W = 4,
   localparam int SEL_W  = $clog2(FIELD_W)
) (
   input  logic [FIELD_W-1:0] field,
   input  logic [SEL_W-1:0]   sel,
   input  logic               pred_bit,
   input  vbc_pkg::vbc_mode_t mode,
   output logic               active,
   output logic               counted,
   output logic               pass
);

   logic test_bit;

   assign test_bit = pred_bit ? field[sel] : mode.sub_val;
   assign active   = pred_bit | mode.sub_en;
   assign counted  = pred_bit;
   assign pass     = mode.force_pass | ~(test_bit ^ mode.want_set);

endmodule

// File: rtl/vbc_scan_ctrl.sv
module vbc_scan_ctrl #(
   parameter int MAX_VL    = 64,
   parameter int CRF_COUNT = 128,
   parameter int FIELD_W   = 4,
   localparam int VL_W     = $clog2(MAX_VL + 1),
   localparam int IDX_W    = $clog2(MAX_VL),
   localparam int FLD_W    = $clog2(CRF_COUNT),
   localparam int SEL_W    = $clog2(FIELD_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [VL_W-1:0]    vl_in,
   input  logic [FLD_W-1:0]   base_in,
   input  logic [SEL_W-1:0]   sel_in,
   input  logic [MAX_VL-1:0]  mask_in,
   input  vbc_pkg::vbc_mode_t mode_in,
   input  logic               el_active,
   input  logic               el_counted,
   input  logic               el_pass,
   output vbc_pkg::vbc_mode_t mode_q,
   output logic [FLD_W-1:0]   base_q,
   output logic [SEL_W-1:0]   sel_q,
   output logic               cur_pred,
   output logic [IDX_W-1:0]   issue_idx,
   output logic               rd_en,
   output logic               busy,
   output logic               done,
   output logic               taken,
   output logic               link_we,
   output logic [VL_W-1:0]    vl_out,
   output logic               vl_trunc,
   output logic [VL_W-1:0]    tested_cnt
);
   import vbc_pkg::*;

   vbc_state_t        state;
   logic [VL_W-1:0]   vl_q;
   logic [MAX_VL-1:0] mask_q;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  nxt_idx;
   logic              acc;
   logic [VL_W-1:0]   cnt;

   logic              merged;
   logic              acc_next;
   logic              hit_trunc;
   logic              hit_early;
   logic              last_el;
   logic              finish;
   logic [VL_W-1:0]   cnt_next;
   logic [VL_W-1:0]   idx_ext;

   assign nxt_idx   = idx + IDX_W'(1);
   assign idx_ext   = VL_W'(idx);
   assign cur_pred  = mask_q[idx];
   assign busy      = (state != ST_IDLE);

   assign merged    = mode_q.all_mode ? (acc & el_pass) : (acc | el_pass);
   assign acc_next  = el_active ? merged : acc;
   assign hit_trunc = el_active & mode_q.trunc_en & (el_pass == mode_q.trunc_on);
   assign hit_early = el_active & (mode_q.all_mode ? ~el_pass : el_pass);
   assign last_el   = (idx_ext + VL_W'(1)) == vl_q;
   assign finish    = (state == ST_SCAN) & (hit_trunc | hit_early | last_el);
   assign cnt_next  = cnt + VL_W'(el_counted);

   always_comb begin
      issue_idx = '0;
      rd_en     = 1'b0;
      case (state)
         ST_PRIME: begin
            issue_idx = '0;
            rd_en     = mask_q[0];
         end
         ST_SCAN: begin
            issue_idx = nxt_idx;
            rd_en     = ~finish & mask_q[nxt_idx];
         end
         default: begin
            issue_idx = '0;
            rd_en     = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         vl_q       <= '0;
         mask_q     <= '0;
         base_q     <= '0;
         sel_q      <= '0;
         mode_q     <= '0;
         idx        <= '0;
         acc        <= 1'b0;
         cnt        <= '0;
         done       <= 1'b0;
         taken      <= 1'b0;
         link_we    <= 1'b0;
         vl_out     <= '0;
         vl_trunc   <= 1'b0;
         tested_cnt <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  vl_q   <= vl_in;
                  mask_q <= mask_in;
                  base_q <= base_in;
                  sel_q  <= sel_in;
                  mode_q <= mode_in;
                  idx    <= '0;
                  acc    <= mode_in.all_mode;
                  cnt    <= '0;
                  if (vl_in == '0) begin
                     done       <= 1'b1;
                     taken      <= mode_in.all_mode;
                     link_we    <= mode_in.link_req &
                                   (~mode_in.link_on_taken | mode_in.all_mode);
                     vl_out     <= '0;
                     vl_trunc   <= 1'b0;
                     tested_cnt <= '0;
                  end else begin
                     state <= ST_PRIME;
                  end
               end
            end
            ST_PRIME: begin
               state <= ST_SCAN;
            end
            ST_SCAN: begin
               acc <= acc_next;
               cnt <= cnt_next;
               idx <= nxt_idx;
               if (finish) begin
                  state      <= ST_IDLE;
                  done       <= 1'b1;
                  taken      <= acc_next;
                  link_we    <= mode_q.link_req &
                                (~mode_q.link_on_taken | acc_next);
                  vl_trunc   <= hit_trunc;
                  vl_out     <= hit_trunc
                                ? (mode_q.trunc_incl ? idx_ext + VL_W'(1) : idx_ext)
                                : vl_q;
                  tested_cnt <= cnt_next;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done); // R12

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(taken) && $stable(vl_out) &&
                             $stable(tested_cnt) && $stable(vl_trunc))); // R12

   AST_NO_READ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !rd_en); // R5

   AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> busy); // R5

   AST_CNT_LE_VL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (tested_cnt <= vl_q)); // R9

   AST_TRUNC_LE_VL: assert property (@(posedge clk) disable iff (!rst_n)
      (done && vl_trunc) |-> (vl_out <= vl_q)); // R8

   AST_LINK_NEEDS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (done && link_we && mode_q.link_on_taken) |-> taken); // R10

   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(vl_q) && $stable(mask_q))); // R13

   AST_START_VL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |-> (vl_in <= VL_W'(MAX_VL))); // R11

endmodule

// File: rtl/vbc_eval.sv
module vbc_eval #(
   parameter int MAX_VL    = 64,
   parameter int CRF_COUNT = 128,
   parameter int FIELD_W   = 4,
   localparam int VL_W     = $clog2(MAX_VL + 1),
   localparam int IDX_W    = $clog2(MAX_VL),
   localparam int FLD_W    = $clog2(CRF_COUNT),
   localparam int SEL_W    = $clog2(FIELD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VL_W-1:0]   vl_in,
   input  logic [FLD_W-1:0]  base_field,
   input  logic [SEL_W-1:0]  bit_sel,
   input  logic [MAX_VL-1:0] pred_mask,
   input  logic              all_mode,
   input  logic              force_pass,
   input  logic              want_set,
   input  logic              sub_en,
   input  logic              sub_val,
   input  logic              trunc_en,
   input  logic              trunc_on,
   input  logic              trunc_incl,
   input  logic              link_req,
   input  logic              link_on_taken,
   output logic              rd_en,
   output logic [FLD_W-1:0]  rd_addr,
   input  logic [FIELD_W-1:0] rd_data,
   output logic              busy,
   output logic              done,
   output logic              taken,
   output logic              link_we,
   output logic [VL_W-1:0]   vl_out,
   output logic              vl_trunc,
   output logic [VL_W-1:0]   tested_cnt
);
   import vbc_pkg::*;

   if (MAX_VL < 2) begin : g_chk_vl
      $error("vbc_eval: MAX_VL must be at least 2");
   end
   if (MAX_VL > CRF_COUNT) begin : g_chk_fields
      $error("vbc_eval: MAX_VL must not exceed CRF_COUNT");
   end
   if ((FIELD_W < 2) || ((FIELD_W & (FIELD_W - 1)) != 0)) begin : g_chk_fw
      $error("vbc_eval: FIELD_W must be a power of two, at least 2");
   end

   vbc_mode_t        mode_in;
   vbc_mode_t        mode_q;
   logic [FLD_W-1:0] base_q;
   logic [SEL_W-1:0] sel_q;
   logic             cur_pred;
   logic [IDX_W-1:0] issue_idx;
   logic             el_active;
   logic             el_counted;
   logic             el_pass;

   always_comb begin
      mode_in.all_mode      = all_mode;
      mode_in.force_pass    = force_pass;
      mode_in.want_set      = want_set;
      mode_in.sub_en        = sub_en;
      mode_in.sub_val       = sub_val;
      mode_in.trunc_en      = trunc_en;
      mode_in.trunc_on      = trunc_on;
      mode_in.trunc_incl    = trunc_incl;
      mode_in.link_req      = link_req;
      mode_in.link_on_taken = link_on_taken;
   end

   vbc_scan_ctrl #(
      .MAX_VL    (MAX_VL),
      .CRF_COUNT (CRF_COUNT),
      .FIELD_W   (FIELD_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .vl_in      (vl_in),
      .base_in    (base_field),
      .sel_in     (bit_sel),
      .mask_in    (pred_mask),
      .mode_in    (mode_in),
      .el_active  (el_active),
      .el_counted (el_counted),
      .el_pass    (el_pass),
      .mode_q     (mode_q),
      .base_q     (base_q),
      .sel_q      (sel_q),
      .cur_pred   (cur_pred),
      .issue_idx  (issue_idx),
      .rd_en      (rd_en),
      .busy       (busy),
      .done       (done),
      .taken      (taken),
      .link_we    (link_we),
      .vl_out     (vl_out),
      .vl_trunc   (vl_trunc),
      .tested_cnt (tested_cnt)
   );

   vbc_field_addr #(
      .CRF_COUNT (CRF_COUNT),
      .MAX_VL    (MAX_VL)
   ) u_addr (
      .base (base_q),
      .idx  (issue_idx),
      .addr (rd_addr)
   );

   vbc_elem_test #(
      .FIELD_W (FIELD_W)
   ) u_test (
      .field    (rd_data),
      .sel      (sel_q),
      .pred_bit (cur_pred),
      .mode     (mode_q),
      .active   (el_active),
      .counted  (el_counted),
      .pass     (el_pass)
   );

   AST_FORCED_NO_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_q.force_pass && mode_q.all_mode && !vl_trunc) |-> taken); // R2

endmodule

// File: tb/tb_vbc_eval.sv
`timescale 1ns/1ps
module tb_vbc_eval;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [6:0]  vl_in = '0;
   logic [6:0]  base_field = '0;
   logic [1:0]  bit_sel = '0;
   logic [63:0] pred_mask = '0;
   logic        all_mode = 0, force_pass = 0, want_set = 0, sub_en = 0, sub_val = 0;
   logic        trunc_en = 0, trunc_on = 0, trunc_incl = 0, link_req = 0, link_on_taken = 0;
   logic        rd_en;
   logic [6:0]  rd_addr;
   logic [3:0]  rd_data = '0;
   logic        busy, done, taken, link_we, vl_trunc;
   logic [6:0]  vl_out, tested_cnt;

   int errors = 0;
   int checks = 0;
   int rd_count = 0;

   always #10 clk = ~clk;

   vbc_eval dut (
      .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
      .base_field(base_field), .bit_sel(bit_sel), .pred_mask(pred_mask),
      .all_mode(all_mode), .force_pass(force_pass), .want_set(want_set),
      .sub_en(sub_en), .sub_val(sub_val), .trunc_en(trunc_en),
      .trunc_on(trunc_on), .trunc_incl(trunc_incl), .link_req(link_req),
      .link_on_taken(link_on_taken), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .busy(busy), .done(done), .taken(taken),
      .link_we(link_we), .vl_out(vl_out), .vl_trunc(vl_trunc),
      .tested_cnt(tested_cnt)
   );

   function automatic logic [3:0] cr_of(input int f);
      return 4'((f * 7 + (f >> 3)) & 15);
   endfunction

   always @(posedge clk) begin
      if (rd_en) begin
         rd_data <= cr_of(int'(rd_addr));
         rd_count++;
      end
   end

   function automatic logic [63:0] mix(input logic [63:0] s);
      logic [63:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 7);
      x = x ^ (x << 17);
      return x;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // Arithmetic model of one scan
   task automatic model(input int vl, input int base, input int sel,
                        input logic [63:0] mask, input logic [9:0] m,
                        output int e_taken, output int e_trunc, output int e_vlo,
                        output int e_cnt, output int e_lat, output int e_lw);
      int acc, exitk;
      bit am, fp, ws, se, sv, te, to, ti, lr, lt;
      {am, fp, ws, se, sv, te, to, ti, lr, lt} = m;
      acc = am; e_cnt = 0; e_trunc = 0; e_vlo = vl; exitk = vl - 1;
      for (int i = 0; i < vl; i++) begin
         int tb, ps;
         if (!mask[i] && !se) continue;
         tb = mask[i] ? int'(cr_of((base + i) % 128) >> sel) & 1 : int'(sv);
         ps = (fp || (tb == int'(ws))) ? 1 : 0;
         if (mask[i]) e_cnt++;
         acc = am ? (acc & ps) : (acc | ps);
         if (te && (ps == int'(to))) begin
            e_trunc = 1; e_vlo = ti ? i + 1 : i; exitk = i; break;
         end
         if (am ? (ps == 0) : (ps == 1)) begin
            exitk = i; break;
         end
      end
      e_taken = acc;
      e_lat = (vl == 0) ? 1 : exitk + 3;
      e_lw = (lr && (!lt || acc != 0)) ? 1 : 0;
   endtask

   task automatic run(input int vl, input int base, input int sel,
                      input logic [63:0] mask, input logic [9:0] m,
                      input bit poke_busy);
      int e_taken, e_trunc, e_vlo, e_cnt, e_lat, e_lw, lat;
      model(vl, base, sel, mask, m, e_taken, e_trunc, e_vlo, e_cnt, e_lat, e_lw);
      @(negedge clk);
      rd_count = 0;
      vl_in = 7'(vl); base_field = 7'(base); bit_sel = 2'(sel); pred_mask = mask;
      {all_mode, force_pass, want_set, sub_en, sub_val, trunc_en, trunc_on,
       trunc_incl, link_req, link_on_taken} = m;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 200) begin
         if (poke_busy && lat == 10) begin
            // R13: a start while busy with different inputs must be ignored
            vl_in = 7'd0; all_mode = ~all_mode; pred_mask = '0; start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(posedge clk);
         @(negedge clk);
         lat++;
      end
      start = 1'b0;
      chk(lat == e_lat, "R12", "done latency", lat, e_lat);
      chk(int'(taken) == e_taken, "R3/R4 R2", "taken", int'(taken), e_taken);
      chk(int'(vl_trunc) == e_trunc, "R8", "vl_trunc", int'(vl_trunc), e_trunc);
      chk(int'(vl_out) == e_vlo, "R8", "vl_out", int'(vl_out), e_vlo);
      chk(int'(tested_cnt) == e_cnt, "R9 R6 R7", "tested_cnt", int'(tested_cnt), e_cnt);
      chk(int'(link_we) == e_lw, "R10", "link_we", int'(link_we), e_lw);
      chk(rd_count == e_cnt, "R5 R1", "read count", rd_count, e_cnt);
      @(negedge clk);
      chk(!done, "R12", "done pulse width", int'(done), 0);
   endtask

   initial begin
      #4000000;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      chk(!busy && !done && !taken && !vl_trunc && !rd_en && tested_cnt == 0,
          "R12", "reset outputs", int'({busy, done, taken, vl_trunc, rd_en}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: zero length in both reductions
      run(0, 5, 0, '1, 10'b1000000010, 1'b0);
      run(0, 5, 0, '1, 10'b0000000011, 1'b0);

      // R13: start while busy, long forced-pass all-mode scan
      run(64, 100, 2, mix(64'h1234_5678_9abc_def1), 10'b1100000000, 1'b1);

      // Sweep every combination of the eight decision mode bits
      for (int c = 0; c < 256; c++) begin
         for (int p = 0; p < 4; p++) begin
            logic [9:0]  m;
            logic [63:0] mk;
            int vl, base;
            m[9:2] = 8'(c);
            m[1]   = ~p[1] | c[2];
            m[0]   = p[0] ^ c[5];
            case (p)
               0: begin vl = 5;  base = 3;   mk = '1; end
               1: begin vl = 64; base = 100; mk = mix(64'(c * 977 + 13)); end
               2: begin vl = 17; base = 126; mk = mix(64'(c + 5)) & mix(64'(c * 31 + 2)); end
               default: begin vl = 1 + (c % 9); base = 127; mk = mix(64'(c ^ 77)); end
            endcase
            run(vl, base, (c + p) % 4, mk, m, 1'b0);
         end
      end

      summary();
      $finish;
   end

endmodule